// File: doc/BRIEF.md
# Boot Microcode Loader Sequencer

This block steps a small table-driven sequencer after reset so that boot microcode is copied, one word at a time, into a writable control store. The sequencer keeps a 4-bit state that is always even. The top bit of an internal word counter supplies the low bit of a 5-bit table index. Each table word gives the next state and four active-low strobes: counter clear, run, write-low-half and write-high-half.

Each pass of the copy loop visits eight states and takes eight clocks. It pulses the high-half write strobe, then the low-half write strobe, and then increments the word counter. When the counter's top bit becomes set, the sequencer clears the counter and parks in a run loop. In that loop it holds the run strobe low for good.

The counter value is brought out so that the surrounding logic can address the control store and the boot image. The table can be held either in its logical order or as a bit-reversed image, and both layouts behave the same at the pins. All pins are plain control and status signals. No pin carries a data stream, so the block has no valid/ready handshake.

Top module: `cs_boot_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset is asserted, `apc_o` is 0 and all four strobes (`clr_n_o`, `run_n_o`, `wlo_n_o`, `whi_n_o`) are 1, meaning inactive.
- R2: On the first clock after reset is released, the sequencer leaves its entry state (00 octal). In that same cycle it drives `clr_n_o` low for one clock, forces `apc_o` to 0, and moves to the loop head, state 10 octal.
- R3: At each counter value, the loop drives `whi_n_o` low for exactly one clock. Exactly four clocks later it drives `wlo_n_o` low for one clock. From reset to the run loop, every counter value from 0 to 2^(CNT_W-1)-1 gets exactly one pulse of each.
- R4: `apc_o` changes only in one of two ways. It goes up by exactly one, once per eight-clock loop, on the clock that leaves state 26 octal. Otherwise it goes to 0.
- R5: When the loop head is reached with `apc_msb_o` (bit CNT_W-1 of the counter) set, the sequencer drives `clr_n_o` low for one clock, forces `apc_o` to 0, and enters the run state, 36 octal.
- R6: Once `run_n_o` goes low it stays low on every later clock until reset, whatever value `apc_msb_o` has.
- R7: The table gives identical pin behaviour whether it is stored in logical order (IMG_REV=0) or as a 5-bit bit-reversed image (IMG_REV=1).
- R8: At most one of the four strobes is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; forces state 00 |
| apc_o | output | CNT_W | Word counter value (control store address) |
| apc_msb_o | output | 1 | Counter top bit; this is the status bit that the table index uses |
| clr_n_o | output | 1 | Active-low counter-clear strobe |
| run_n_o | output | 1 | Active-low run strobe |
| wlo_n_o | output | 1 | Active-low low-half write strobe |
| whi_n_o | output | 1 | Active-low high-half write strobe |

## Verification
The hardest situation to bring about is the run loop. It appears only after the counter's top bit has been set by 2^(CNT_W-1) full eight-clock passes, and no input can shortcut those passes. The bench therefore lets the complete copy from reset run its course, about 8200 clocks with the default width. It tallies the write pulses seen at each counter value and then watches the run strobe for several hundred more clocks. To show that a reset during the copy loop restarts cleanly from the entry state, reset is also applied in the middle of a pass.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  localparam int SEQ_STATE_W = 4;
  localparam int SEQ_IDX_W   = SEQ_STATE_W + 1;
  localparam int SEQ_DEPTH   = 1 << SEQ_IDX_W;

  // strb_n order: {clear, run, write low, write high}, all active low
  typedef struct packed {
    logic [SEQ_STATE_W-1:0] nxt;    // next even state, stored halved
    logic [3:0]             strb_n;
    logic                   inc;    // bump the word counter
  } seq_word_t;

  // even state addresses (octal, as used by the index)
  localparam logic [SEQ_IDX_W-1:0] S_ENTRY = 5'o00;
  localparam logic [SEQ_IDX_W-1:0] S_HEAD  = 5'o10;
  localparam logic [SEQ_IDX_W-1:0] S_GAP   = 5'o12;
  localparam logic [SEQ_IDX_W-1:0] S_PREH  = 5'o14;
  localparam logic [SEQ_IDX_W-1:0] S_WRH   = 5'o16;
  localparam logic [SEQ_IDX_W-1:0] S_PAD0  = 5'o20;
  localparam logic [SEQ_IDX_W-1:0] S_PAD1  = 5'o22;
  localparam logic [SEQ_IDX_W-1:0] S_PREL  = 5'o24;
  localparam logic [SEQ_IDX_W-1:0] S_WRL   = 5'o26;
  localparam logic [SEQ_IDX_W-1:0] S_RUN   = 5'o36;

  localparam logic [3:0] STB_IDLE = 4'b1111;
  localparam logic [3:0] STB_CLR  = 4'b0111;
  localparam logic [3:0] STB_RUN  = 4'b1011;
  localparam logic [3:0] STB_WLO  = 4'b1101;
  localparam logic [3:0] STB_WHI  = 4'b1110;

  function automatic logic [SEQ_IDX_W-1:0] rev5(input logic [SEQ_IDX_W-1:0] a);
    logic [SEQ_IDX_W-1:0] r;
    for (int i = 0; i < SEQ_IDX_W; i++) r[i] = a[SEQ_IDX_W-1-i];
    return r;
  endfunction

  function automatic seq_word_t mk(input logic [SEQ_IDX_W-1:0] nxt_addr,
                                   input logic [3:0] s, input logic inc);
    seq_word_t w;
    w.nxt    = nxt_addr[SEQ_IDX_W-1:1];
    w.strb_n = s;
    w.inc    = inc;
    return w;
  endfunction

  // logical table, indexed by {state, status}
  function automatic seq_word_t seq_word(input logic [SEQ_IDX_W-1:0] idx);
    seq_word_t w;
    w = mk(S_ENTRY, STB_IDLE, 1'b0);
    case (idx)
      S_ENTRY, S_ENTRY | 5'd1: w = mk(S_HEAD, STB_CLR,  1'b0);
      S_HEAD:                  w = mk(S_GAP,  STB_IDLE, 1'b0);
      S_HEAD | 5'd1:           w = mk(S_RUN,  STB_CLR,  1'b0);
      S_GAP:                   w = mk(S_PREH, STB_IDLE, 1'b0);
      S_PREH:                  w = mk(S_WRH,  STB_WHI,  1'b0);
      S_WRH:                   w = mk(S_PAD0, STB_IDLE, 1'b0);
      S_PAD0:                  w = mk(S_PAD1, STB_IDLE, 1'b0);
      S_PAD1:                  w = mk(S_PREL, STB_IDLE, 1'b0);
      S_PREL:                  w = mk(S_WRL,  STB_WLO,  1'b0);
      S_WRL:                   w = mk(S_HEAD, STB_IDLE, 1'b1);
      S_RUN, S_RUN | 5'd1:     w = mk(S_RUN,  STB_RUN,  1'b0);
      default:                 w = mk(S_ENTRY, STB_IDLE, 1'b0);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/bootseq_image.sv
module bootseq_image
  import bootseq_pkg::*;
#(
  parameter bit IMG_REV = 1'b1
) (
  input  logic [SEQ_IDX_W-1:0] idx,
  output seq_word_t            word
);

  if (IMG_REV) begin : g_rev
    seq_word_t image [SEQ_DEPTH];
    for (genvar g = 0; g < SEQ_DEPTH; g++) begin : g_fill
      assign image[g] = seq_word(rev5(SEQ_IDX_W'(g)));
    end
    assign word = image[rev5(idx)];
  end else begin : g_lin
    seq_word_t image [SEQ_DEPTH];
    for (genvar g = 0; g < SEQ_DEPTH; g++) begin : g_fill
      assign image[g] = seq_word(SEQ_IDX_W'(g));
    end
    assign word = image[idx];
  end

endmodule

// File: rtl/bootseq_apc.sv
module bootseq_apc #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + ONE;
  end

endmodule

// File: rtl/bootseq_fsm.sv
module bootseq_fsm
  import bootseq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEQ_STATE_W-1:0] nxt,
  input  logic [3:0]             strb_d,
  output logic [SEQ_STATE_W-1:0] state_q,
  output logic [3:0]             strb_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      strb_q  <= STB_IDLE;
    end else begin
      state_q <= nxt;
      strb_q  <= strb_d;
    end
  end

endmodule

// File: rtl/cs_boot_seq.sv
module cs_boot_seq
  import bootseq_pkg::*;
#(
  parameter int CNT_W   = 11,
  parameter bit IMG_REV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] apc_o,
  output logic             apc_msb_o,
  output logic             clr_n_o,
  output logic             run_n_o,
  output logic             wlo_n_o,
  output logic             whi_n_o
);

  localparam int MSB = CNT_W - 1;

  logic [SEQ_STATE_W-1:0] state_q;
  logic [3:0]             strb_q;
  logic [CNT_W-1:0]       cnt;
  seq_word_t              word;

  bootseq_image #(.IMG_REV(IMG_REV)) u_image (
    .idx  ({state_q, cnt[MSB]}),
    .word (word)
  );

  bootseq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt     (word.nxt),
    .strb_d  (word.strb_n),
    .state_q (state_q),
    .strb_q  (strb_q)
  );

  bootseq_apc #(.CNT_W(CNT_W)) u_apc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (~word.strb_n[3]),
    .inc   (word.inc),
    .cnt   (cnt)
  );

  assign apc_o     = cnt;
  assign apc_msb_o = cnt[MSB];
  assign clr_n_o   = strb_q[3];
  assign run_n_o   = strb_q[2];
  assign wlo_n_o   = strb_q[1];
  assign whi_n_o   = strb_q[0];

endmodule

// File: rtl/cs_boot_seq_chk.sv
module cs_boot_seq_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] apc_o,
  input logic             apc_msb_o,
  input logic             clr_n_o,
  input logic             run_n_o,
  input logic             wlo_n_o,
  input logic             whi_n_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R8
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~clr_n_o, ~run_n_o, ~wlo_n_o, ~whi_n_o}));

  // R3
  a_r3_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !whi_n_o |-> ##4 !wlo_n_o);

  // R4
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (apc_o != $past(apc_o)) |-> ((apc_o == $past(apc_o) + ONE) || (apc_o == '0)));

  // R2 / R5
  a_r5_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_o |-> (apc_o == '0));

  // R6
  a_r6_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n_o |=> !run_n_o);

  // status pin tracks counter top bit
  a_r5_msb_pin: assert property (@(posedge clk) disable iff (!rst_n)
    apc_msb_o == apc_o[CNT_W-1]);

endmodule

bind cs_boot_seq cs_boot_seq_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cs_boot_seq_tb_top.sv
`timescale 1ns/1ps
module cs_boot_seq_tb_top;

  localparam int CNT_W = 11;
  localparam int WORDS = 1 << (CNT_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [CNT_W-1:0] apc_a, apc_b;
  logic msb_a, clr_a, run_a, wlo_a, whi_a;
  logic msb_b, clr_b, run_b, wlo_b, whi_b;

  cs_boot_seq #(.CNT_W(CNT_W), .IMG_REV(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .apc_o(apc_a), .apc_msb_o(msb_a),
    .clr_n_o(clr_a), .run_n_o(run_a), .wlo_n_o(wlo_a), .whi_n_o(whi_a));

  cs_boot_seq #(.CNT_W(CNT_W), .IMG_REV(1'b0)) dut_lin_i (
    .clk(clk), .rst_n(rst_n), .apc_o(apc_b), .apc_msb_o(msb_b),
    .clr_n_o(clr_b), .run_n_o(run_b), .wlo_n_o(wlo_b), .whi_n_o(whi_b));

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // behavioural reference
  int m_st, m_cnt;
  bit m_clr, m_run, m_wl, m_wh;
  int hi_seen [WORDS];
  int lo_seen [WORDS];
  int run_cycles;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 'o00; m_cnt = 0;
    m_clr = 1; m_run = 1; m_wl = 1; m_wh = 1;
  endtask

  task automatic model_step();
    bit msb;
    int nst;
    msb = ((m_cnt >> (CNT_W - 1)) & 1) != 0;
    m_clr = 1; m_run = 1; m_wl = 1; m_wh = 1;
    nst = 'o00;
    case (m_st)
      'o00: begin m_clr = 0; m_cnt = 0; nst = 'o10; end
      'o10: if (msb) begin m_clr = 0; m_cnt = 0; nst = 'o36; end
            else nst = 'o12;
      'o12: nst = 'o14;
      'o14: begin m_wh = 0; nst = 'o16; end
      'o16: nst = 'o20;
      'o20: nst = 'o22;
      'o22: nst = 'o24;
      'o24: begin m_wl = 0; nst = 'o26; end
      'o26: if (!msb) begin m_cnt = (m_cnt + 1) % (1 << CNT_W); nst = 'o10; end
      'o36: begin m_run = 0; nst = 'o36; end
      default: nst = 'o00;
    endcase
    m_st = nst;
  endtask

  task automatic compare(input string rq);
    chk(apc_a == m_cnt,  (rq == "") ? "R4" : rq, "apc",   int'(apc_a), m_cnt);
    chk(msb_a == apc_a[CNT_W-1], "R5", "status bit", int'(msb_a), int'(apc_a[CNT_W-1]));
    chk(clr_a == m_clr,  (rq == "") ? "R2" : rq, "clr_n", int'(clr_a), int'(m_clr));
    chk(run_a == m_run,  (rq == "") ? "R6" : rq, "run_n", int'(run_a), int'(m_run));
    chk(wlo_a == m_wl,   (rq == "") ? "R3" : rq, "wlo_n", int'(wlo_a), int'(m_wl));
    chk(whi_a == m_wh,   (rq == "") ? "R3" : rq, "whi_n", int'(whi_a), int'(m_wh));
    chk({apc_b, msb_b, clr_b, run_b, wlo_b, whi_b} == {apc_a, msb_a, clr_a, run_a, wlo_a, whi_a},
        "R7", "linear image vs reversed image apc", int'(apc_b), int'(apc_a));
    chk($countones({~clr_a, ~run_a, ~wlo_a, ~whi_a}) <= 1, "R8", "active strobes",
        $countones({~clr_a, ~run_a, ~wlo_a, ~whi_a}), 1);
  endtask

  task automatic step_cycle();
    model_step();
    @(negedge clk);
    compare("");
    if (!whi_a) hi_seen[apc_a[CNT_W-2:0]]++;
    if (!wlo_a) lo_seen[apc_a[CNT_W-2:0]]++;
    if (!run_a) run_cycles++;
  endtask

  initial begin : main
    int bad_hi, bad_lo, guard;
    foreach (hi_seen[i]) begin hi_seen[i] = 0; lo_seen[i] = 0; end
    run_cycles = 0;

    // R1: reset state
    rst_n = 1'b0;
    model_reset();
    repeat (3) begin @(negedge clk); compare("R1"); end

    // R2: entry then full copy loop (R3, R4), run loop (R5, R6)
    rst_n = 1'b1;
    step_cycle();
    chk(clr_a == 1'b0 && apc_a == '0, "R2", "entry clears counter", int'(clr_a), 0);
    guard = 0;
    while (m_st != 'o36 && guard < 20000) begin step_cycle(); guard++; end
    chk(!clr_a && apc_a == '0, "R5", "clear on wrap", int'(apc_a), 0);
    repeat (300) step_cycle();
    chk(run_cycles >= 300, "R6", "run strobe cycles", run_cycles, 300);

    bad_hi = 0; bad_lo = 0;
    foreach (hi_seen[i]) begin
      if (hi_seen[i] != 1) bad_hi++;
      if (lo_seen[i] != 1) bad_lo++;
    end
    chk(bad_hi == 0, "R3", "words without exactly one high write", bad_hi, 0);
    chk(bad_lo == 0, "R3", "words without exactly one low write", bad_lo, 0);

    // R1: reset during run loop, then mid-pass reset
    @(negedge clk);
    rst_n = 1'b0; model_reset();
    @(negedge clk); compare("R1");
    rst_n = 1'b1;
    repeat (37) step_cycle();
    chk(apc_a == 4, "R4", "counter after 4.5 passes", int'(apc_a), 4);
    rst_n = 1'b0; model_reset();
    @(negedge clk); compare("R1");
    rst_n = 1'b1;
    repeat (20) step_cycle();
    chk(apc_a == 2, "R2", "restart after mid-pass reset", int'(apc_a), 2);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule